// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block chooses which interrupt an 8-bit core takes next. It handles a set of vectors, 16 by default. Each vector has a hardware-set pending flag, a software enable and a 2-bit software priority field. A vector raises a request only when its flag and its enable are both 1. The block sends a request forward only if the request's priority field is strictly above the running level. That level is the 2-bit value the core holds in its condition code, and the block keeps the live copy of it. A software trap is also handled. It cannot be masked and it always beats the vectors.

Arbitration happens only when the core signals the end of an instruction. Among eligible vectors the highest software level wins. If levels are equal, the lowest vector index wins, which is also the highest vector address. When the block accepts a request, it raises an entry strobe for the length of the context-switch sequence. It holds the vector address steady during that time, saves the old level on an internal level stack and loads the winner's level as the new running level. A return strobe pops the stack and restores the earlier level. The pending requests are then weighed again against that level at the next instruction end.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, entry_req is 0, cc_lvl is 3 (every vector masked) and vec_addr is 16'hFFFE.
- R2: Vector i requests only when irq_flag[i] and irq_en[i] are both 1. A flag without its enable, or an enable without its flag, never starts an entry.
- R3: A vector is eligible only if its priority field irq_prio[2i+1:2i] is strictly greater than cc_lvl. So cc_lvl = 3 masks every vector, and a request whose field equals the running level waits.
- R4: A trap request (trap_req high at an instruction end) is taken at any cc_lvl. It goes to address 16'hFFFC, sets cc_lvl to 3 and wins over any pending vector.
- R5: Among eligible vectors the highest priority field wins, and ties go to the lowest index. Vector i is entered at address 16'hFFFA - 2*i.
- R6: An entry starts only on a cycle with instr_end high. entry_req rises in the following cycle, stays high for exactly ENTRY_CYC (10) cycles, and vec_addr holds the entered address during all of them.
- R7: On entry the running level is pushed on the level stack, and cc_lvl takes the winner's priority field.
- R8: An iret pops the level stack into cc_lvl. An iret with an empty stack leaves cc_lvl unchanged.
- R9: lvl_wr loads lvl_wdata into cc_lvl. In a cycle with iret or lvl_wr no entry starts, and iret takes precedence over lvl_wr. Pending requests are weighed against the new level at the next instr_end.
- R10: While entry_req is high, instr_end, iret and lvl_wr have no effect.
- R11: A handler is preempted by a request with a strictly higher field. Nested returns restore the levels in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_flag | input | NVEC | Pending flags from peripherals |
| irq_en | input | NVEC | Per-vector enables |
| irq_prio | input | 2*NVEC | 2-bit priority field per vector |
| trap_req | input | 1 | Software trap request |
| instr_end | input | 1 | Core is at an instruction boundary |
| iret | input | 1 | Return-from-interrupt strobe |
| lvl_wr | input | 1 | Core writes the running level |
| lvl_wdata | input | 2 | Level value written by the core |
| entry_req | output | 1 | Entry sequence in progress |
| vec_addr | output | 16 | Address of the vector being entered |
| cc_lvl | output | 2 | Running level to hold in the condition code |

## Verification
A return and an instruction end can arrive in the same cycle while a request is pending that would be eligible at the old level. The bench drives both strobes together inside a handler. It checks that no entry starts in that cycle and that cc_lvl drops to the popped value. It then checks that a plain instruction end on the next cycle enters the pending vector. A second collision puts an instruction end, a return and a higher-level request in the middle of a running entry. That case is judged by an unbroken 10-cycle entry_req and an unchanged level.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NVEC      = 16,
  parameter int DEPTH     = 16,
  parameter int ENTRY_CYC = 10,
  parameter logic [15:0] RESET_ADDR = 16'hFFFE,
  parameter logic [15:0] TRAP_ADDR  = 16'hFFFC,
  parameter logic [15:0] VEC0_ADDR  = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NVEC-1:0]   irq_flag,
  input  logic [NVEC-1:0]   irq_en,
  input  logic [2*NVEC-1:0] irq_prio,
  input  logic              trap_req,
  input  logic              instr_end,
  input  logic              iret,
  input  logic              lvl_wr,
  input  logic [1:0]        lvl_wdata,
  output logic              entry_req,
  output logic [15:0]       vec_addr,
  output logic [1:0]        cc_lvl
);
  localparam int IDXW = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int CW   = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;

  logic [1:0]      cur_lvl;
  logic [1:0]      stk [DEPTH];
  logic [SPW-1:0]  sp;
  logic            busy;
  logic [CW-1:0]   cnt;
  logic [15:0]     addr_q;

  logic            win_ok;
  logic [IDXW-1:0] win_idx;
  logic [1:0]      win_lvl;

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (irq_flag[i] && irq_en[i] && irq_prio[2*i +: 2] > cur_lvl &&
          (!win_ok || irq_prio[2*i +: 2] >= win_lvl)) begin
        win_ok  = 1'b1;
        win_idx = i[IDXW-1:0];
        win_lvl = irq_prio[2*i +: 2];
      end
    end
  end

  wire            take    = instr_end && (trap_req || win_ok);
  wire [15:0]     win_adr = VEC0_ADDR - (16'(win_idx) << 1);
  wire [SW-1:0]   push_i  = SW'(sp);
  wire [SW-1:0]   pop_i   = SW'(sp - 1'b1);
  wire            last    = (cnt == CW'(ENTRY_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= 2'd3;
      sp      <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
      addr_q  <= RESET_ADDR;
    end else if (busy) begin
      busy <= !last;
      cnt  <= last ? '0 : cnt + 1'b1;
    end else if (iret) begin
      if (sp != '0) begin
        cur_lvl <= stk[pop_i];
        sp      <= sp - 1'b1;
      end
    end else if (lvl_wr) begin
      cur_lvl <= lvl_wdata;
    end else if (take) begin
      busy    <= 1'b1;
      cnt     <= '0;
      cur_lvl <= trap_req ? 2'd3 : win_lvl;
      addr_q  <= trap_req ? TRAP_ADDR : win_adr;
      if (sp != SPW'(DEPTH)) sp <= sp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && !iret && !lvl_wr && take && sp != SPW'(DEPTH))
      stk[push_i] <= cur_lvl;
  end

  assign entry_req = busy;
  assign vec_addr  = addr_q;
  assign cc_lvl    = cur_lvl;

  p_start_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(entry_req) |-> $past(instr_end));
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req && $past(entry_req) |-> $stable(vec_addr));
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(ENTRY_CYC));
  p_masked_trap_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(entry_req) && $past(cc_lvl) == 2'd3 |-> vec_addr == TRAP_ADDR);
  p_level_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(entry_req) && vec_addr != TRAP_ADDR |-> cc_lvl > $past(cc_lvl));
  p_empty_iret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_req && iret && sp == '0 |=> $stable(cc_lvl));
  p_busy_lvl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req && $past(entry_req) |-> $stable(cc_lvl));
endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_flag = '0;
  logic [15:0] irq_en = '0;
  logic [31:0] irq_prio = '0;
  logic        trap_req = 1'b0;
  logic        instr_end = 1'b0;
  logic        iret = 1'b0;
  logic        lvl_wr = 1'b0;
  logic [1:0]  lvl_wdata = '0;
  logic        entry_req;
  logic [15:0] vec_addr;
  logic [1:0]  cc_lvl;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (.clk, .rst_n, .irq_flag, .irq_en, .irq_prio,
    .trap_req, .instr_end, .iret, .lvl_wr, .lvl_wdata, .entry_req, .vec_addr, .cc_lvl);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_vec(input int i, input bit f, input bit e, input int p);
    irq_flag[i] = f; irq_en[i] = e; irq_prio[2*i +: 2] = 2'(p);
  endtask

  task automatic pulse_end();
    @(negedge clk) instr_end = 1'b1;
    @(negedge clk) instr_end = 1'b0;
  endtask

  task automatic do_iret();
    @(negedge clk) iret = 1'b1;
    @(negedge clk) iret = 1'b0;
  endtask

  task automatic set_lvl(input int v);
    @(negedge clk) begin lvl_wr = 1'b1; lvl_wdata = 2'(v); end
    @(negedge clk) lvl_wr = 1'b0;
  endtask

  task automatic expect_entry(input string req, input int addr, input int lvl);
    int n = 0;
    pulse_end();
    chk({req, " entry"}, int'(entry_req), 1);
    chk({req, " addr"}, int'(vec_addr), addr);
    chk({req, " level"}, int'(cc_lvl), lvl);
    while (entry_req && n < 40) begin
      n++;
      chk({req, " R6 addr held"}, int'(vec_addr), addr);
      @(negedge clk);
    end
    chk("R6 entry length", n, 10);
  endtask

  task automatic expect_none(input string req);
    pulse_end();
    chk(req, int'(entry_req), 0);
    @(negedge clk);
    chk(req, int'(entry_req), 0);
  endtask

  task automatic t_reset();
    chk("R1 entry_req", int'(entry_req), 0);
    chk("R1 cc_lvl", int'(cc_lvl), 3);
    chk("R1 vec_addr", int'(vec_addr), 16'hFFFE);
  endtask

  task automatic t_gating();
    set_lvl(0);
    set_vec(2, 1, 0, 1);
    expect_none("R2 flag only");
    set_vec(2, 0, 1, 1);
    expect_none("R2 enable only");
    set_vec(2, 0, 0, 0);
  endtask

  task automatic t_mask();
    set_lvl(3);
    set_vec(0, 1, 1, 3);
    expect_none("R3 level 3 masks");
    set_lvl(1);
    set_vec(0, 1, 1, 1);
    expect_none("R3 equal level waits");
    set_vec(0, 0, 0, 0);
  endtask

  task automatic t_trap();
    set_lvl(3);
    set_vec(0, 1, 1, 3);
    trap_req = 1'b1;
    expect_entry("R4 trap", 16'hFFFC, 3);
    trap_req = 1'b0;
    set_vec(0, 0, 0, 0);
    do_iret();
    chk("R8 pop after trap", int'(cc_lvl), 3);
  endtask

  task automatic t_order();
    set_lvl(0);
    set_vec(1, 1, 1, 2);
    set_vec(3, 1, 1, 3);
    set_vec(5, 1, 1, 3);
    expect_entry("R5 R7 level then index", 16'hFFF4, 3);
    set_vec(1, 0, 0, 0); set_vec(3, 0, 0, 0); set_vec(5, 0, 0, 0);
    do_iret();
    chk("R8 restore 0", int'(cc_lvl), 0);
  endtask

  task automatic t_nest();
    set_vec(4, 1, 1, 1);
    expect_entry("R11 first", 16'hFFF2, 1);
    set_vec(4, 0, 0, 0);
    set_vec(6, 1, 1, 1);
    expect_none("R11 equal no preempt");
    set_vec(7, 1, 1, 2);
    expect_entry("R11 preempt", 16'hFFEC, 2);
    set_vec(6, 0, 0, 0); set_vec(7, 0, 0, 0);
    do_iret();
    chk("R11 unwind 1", int'(cc_lvl), 1);
    do_iret();
    chk("R11 unwind 0", int'(cc_lvl), 0);
    do_iret();
    chk("R8 empty stack iret", int'(cc_lvl), 0);
  endtask

  task automatic t_conflict();
    set_vec(2, 1, 1, 1);
    expect_entry("R7 enter", 16'hFFF6, 1);
    set_vec(2, 0, 0, 0);
    set_vec(9, 1, 1, 1);
    @(negedge clk) begin instr_end = 1'b1; iret = 1'b1; end
    @(negedge clk) begin instr_end = 1'b0; iret = 1'b0; end
    chk("R9 iret blocks entry", int'(entry_req), 0);
    chk("R9 iret restored", int'(cc_lvl), 0);
    expect_entry("R9 next boundary", 16'hFFE8, 1);
    set_vec(9, 0, 0, 0);
    @(negedge clk) begin iret = 1'b1; lvl_wr = 1'b1; lvl_wdata = 2'd2; end
    @(negedge clk) begin iret = 1'b0; lvl_wr = 1'b0; end
    chk("R9 iret over lvl_wr", int'(cc_lvl), 0);
  endtask

  task automatic t_busy();
    int n = 1;
    set_vec(8, 1, 1, 1);
    pulse_end();
    chk("R10 entry", int'(entry_req), 1);
    set_vec(10, 1, 1, 3);
    @(negedge clk) begin instr_end = 1'b1; iret = 1'b1; lvl_wr = 1'b1; lvl_wdata = 2'd0; end
    @(negedge clk) begin instr_end = 1'b0; iret = 1'b0; lvl_wr = 1'b0; end
    n = n + 2;
    chk("R10 level kept", int'(cc_lvl), 1);
    chk("R10 addr kept", int'(vec_addr), 16'hFFEA);
    while (entry_req && n < 40) begin n++; @(negedge clk); end
    chk("R10 length unbroken", n, 11);
    set_vec(8, 0, 0, 0);
    expect_entry("R10 later preempt", 16'hFFE6, 3);
    set_vec(10, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_mask();
    t_trap();
    t_order();
    t_nest();
    t_conflict();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule